// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells a memory controller's command arbiter when a refresh is owed. An interval timer runs once initialization is complete. Each time it expires, one refresh is added to a debt counter. While the debt is non-zero, the block raises a refresh request. The arbiter may hold that request off while read and write traffic is busy. It answers with a one-cycle grant each time it issues a refresh command. The postponed refreshes can then be issued one after another as a burst.

Once the debt reaches a programmable limit, an urgent flag asks the arbiter to place refresh ahead of all other traffic. This keeps the catch-up burst inside the retention window. After each accepted grant, the request is masked for the refresh cycle time, so the next refresh is not issued while the device is still busy with the previous one. A hot-mode input selects a shorter interval, at one quarter of the normal value by default, for operation above the normal temperature range. Every timing value is a parameter counted in clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears the debt, the interval timer and the busy-gap counter. In the cycle after reset, `ref_req` and `ref_urgent` are low.
- R2: While `init_done` is low, the interval timer holds, no debt accrues and `ref_req` stays low.
- R3: The first interval expiry happens on the TREFI_CYC-th rising edge at which `init_done` is high. Each expiry adds one to the debt. `ref_req` is high exactly when the debt is non-zero, `init_done` is high and no busy gap is running.
- R4: A grant sampled while `ref_req` is high subtracts one from the debt and starts a busy gap. During the gap, `ref_req` is low for exactly TRFC_CYC cycles. A grant sampled while `ref_req` is low has no effect on the debt.
- R5: `ref_urgent` is high exactly when `ref_req` is high and the debt is at least URGENT_LVL.
- R6: The debt saturates at DEBT_MAX. Expiries beyond that are lost. After a long wait with no grants, exactly DEBT_MAX grants are accepted before the request drops.
- R7: When an interval expiry and an accepted grant fall on the same edge, the debt is left unchanged, including when it is at DEBT_MAX.
- R8: At each expiry the timer reloads to TREFI_HOT_CYC cycles when `hot_mode` is high and to TREFI_CYC cycles when it is low. A change of `hot_mode` therefore takes effect only at the next reload, and it does not change the debt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | input | 1 | Memory initialization finished; enables timer and requests |
| hot_mode | input | 1 | Selects the shortened refresh interval at the next reload |
| ref_grant | input | 1 | One-cycle pulse: arbiter issued a refresh command |
| ref_req | output | 1 | At least one refresh owed and device not busy |
| ref_urgent | output | 1 | Debt at or above the postpone limit; refresh must go first |

## Verification
Two events can land on the same clock edge: the interval timer expiring and the arbiter's grant being accepted. The bench provokes this by driving the grant in the cycle just before a known expiry, while exactly one refresh is owed. It then judges the outcome at the end of the busy gap. The request must return high, because the debt is still one. A design that loses either the increment or the decrement shows a wrong request level there, or one interval later. The saturated case is covered indirectly, by counting exactly DEBT_MAX grants in a drain burst that starts right after an expiry.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int TREFI_CYC     = 100,
  parameter int TREFI_HOT_CYC = 25,
  parameter int TRFC_CYC      = 4,
  parameter int DEBT_MAX      = 8,
  parameter int URGENT_LVL    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic init_done,
  input  logic hot_mode,
  input  logic ref_grant,
  output logic ref_req,
  output logic ref_urgent
);
  localparam int TW = $clog2(TREFI_CYC + 1);
  localparam int GW = $clog2(TRFC_CYC + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [TW-1:0] RLD_NORM = TW'(TREFI_CYC - 1);
  localparam logic [TW-1:0] RLD_HOT  = TW'(TREFI_HOT_CYC - 1);

  logic [TW-1:0] tmr;
  logic [GW-1:0] gap;
  logic [DW-1:0] debt;

  wire tick = init_done && (tmr == '0);
  wire take = ref_grant && ref_req;
  wire bump = tick && ((debt != DW'(DEBT_MAX)) || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr  <= RLD_NORM;
      gap  <= '0;
      debt <= '0;
    end else begin
      if (tick)
        tmr <= hot_mode ? RLD_HOT : RLD_NORM;
      else if (init_done)
        tmr <= tmr - 1'b1;

      if (take)
        gap <= GW'(TRFC_CYC);
      else if (gap != '0)
        gap <= gap - 1'b1;

      debt <= debt + DW'(bump) - DW'(take);
    end
  end

  assign ref_req    = init_done && (debt != '0) && (gap == '0);
  assign ref_urgent = ref_req && (debt >= DW'(URGENT_LVL));
endmodule

module refresh_sched_chk #(
  parameter int DEBT_MAX = 8,
  parameter int DW       = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          init_done,
  input logic          ref_grant,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic          tick,
  input logic [DW-1:0] debt
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ref_req && !ref_urgent));

  a_r2_no_req_before_init: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !ref_req);

  a_r4_gap_after_grant: assert property (@(posedge clk) disable iff (rst)
    (ref_grant && ref_req) |=> !ref_req);

  a_r5_urgent_needs_req: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> ref_req);

  a_r6_debt_bound: assert property (@(posedge clk) disable iff (rst)
    debt <= DW'(DEBT_MAX));

  a_r7_tick_and_grant: assert property (@(posedge clk) disable iff (rst)
    (tick && ref_grant && ref_req) |=> (debt == $past(debt)));
endmodule

bind refresh_sched refresh_sched_chk #(.DEBT_MAX(DEBT_MAX), .DW(DW)) chk (
  .clk(clk), .rst(rst), .init_done(init_done), .ref_grant(ref_grant),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .tick(tick), .debt(debt)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_done = 1'b0;
  logic hot_mode = 1'b0;
  logic ref_grant = 1'b0;
  logic ref_req, ref_urgent;
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (init_done) cyc <= cyc + 1;

  refresh_sched uut (
    .clk(clk), .rst(rst), .init_done(init_done), .hot_mode(hot_mode),
    .ref_grant(ref_grant), .ref_req(ref_req), .ref_urgent(ref_urgent)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cyc=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic at(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic grant_now;
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 req after reset", ref_req, 1'b0);
    chk("R1 urgent after reset", ref_urgent, 1'b0);
  endtask

  task automatic t_no_init;
    int seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (ref_req) seen++;
    end
    total++;
    if (seen != 0) begin
      bad++;
      $display("FAIL R2 req seen before init actual=%0d expected=0", seen);
    end
    init_done = 1'b1;
  endtask

  task automatic t_first_interval;
    at(99);  chk("R3 no req before first expiry", ref_req, 1'b0);
    at(100); chk("R3 req at first expiry", ref_req, 1'b1);
  endtask

  task automatic t_gap;
    at(200); chk("R3 req with debt 2", ref_req, 1'b1);
    grant_now;
    for (int i = 0; i < 4; i++) begin
      chk("R4 req masked in gap", ref_req, 1'b0);
      @(negedge clk);
    end
    chk("R4 req back after gap", ref_req, 1'b1);
    grant_now;
    at(299); chk("R4 debt cleared by two grants", ref_req, 1'b0);
  endtask

  task automatic t_urgent_sat;
    at(799);  chk("R5 urgent below limit", ref_urgent, 1'b0);
    at(800);  chk("R5 urgent at limit", ref_urgent, 1'b1);
    at(1100); chk("R5 urgent while saturated", ref_urgent, 1'b1);
    begin
      int n = 0;
      repeat (60) begin
        if (ref_req) begin
          n++;
          ref_grant = 1'b1;
        end
        @(negedge clk);
        ref_grant = 1'b0;
      end
      total++;
      if (n != 8) begin
        bad++;
        $display("FAIL R6 grants in drain actual=%0d expected=8", n);
      end
    end
    chk("R5 urgent gone after drain", ref_urgent, 1'b0);
    at(1199); chk("R6 no debt left after drain", ref_req, 1'b0);
  endtask

  task automatic t_same_edge;
    at(1200); chk("R3 req after expiry", ref_req, 1'b1);
    at(1299); chk("R7 req before shared edge", ref_req, 1'b1);
    grant_now;
    chk("R7 gap after shared edge", ref_req, 1'b0);
    at(1304); chk("R7 debt kept on shared edge", ref_req, 1'b1);
    grant_now;
    at(1399); chk("R7 debt empty afterwards", ref_req, 1'b0);
  endtask

  task automatic t_hot;
    at(1400); chk("R3 req at 1400", ref_req, 1'b1);
    grant_now;
    hot_mode = 1'b1;
    at(1499); chk("R8 old interval still running", ref_req, 1'b0);
    at(1500); chk("R8 expiry on old interval", ref_req, 1'b1);
    grant_now;
    at(1524); chk("R8 before short expiry", ref_req, 1'b0);
    at(1525); chk("R8 short expiry", ref_req, 1'b1);
    grant_now;
    at(1550); chk("R8 second short expiry", ref_req, 1'b1);
    grant_now;
    hot_mode = 1'b0;
    at(1574); chk("R8 short reload still applies", ref_req, 1'b0);
    at(1575); chk("R8 last short expiry", ref_req, 1'b1);
    grant_now;
    at(1674); chk("R8 normal interval restored", ref_req, 1'b0);
    at(1675); chk("R8 normal expiry", ref_req, 1'b1);
    grant_now;
  endtask

  task automatic t_stray_grant;
    at(1680);
    grant_now;
    at(1690); chk("R4 stray grant no underflow", ref_req, 1'b0);
    chk("R4 stray grant no urgent", ref_urgent, 1'b0);
    at(1774); chk("R4 quiet until next expiry", ref_req, 1'b0);
    at(1775); chk("R4 next expiry after stray grant", ref_req, 1'b1);
    grant_now;
  endtask

  initial begin
    t_reset;
    t_no_init;
    t_first_interval;
    t_gap;
    t_urgent_sat;
    t_same_edge;
    t_hot;
    t_stray_grant;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired at cyc=%0d actual=running expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule